// File: doc/BRIEF.md
# Polyphase Horizontal Line Resampler

This block resizes one line of a single 8-bit image component along the horizontal axis. Each output pixel comes from an 8-tap polyphase FIR filter. The filter reads eight neighbouring source pixels and applies one of 32 coefficient sets. The set is chosen from the fractional part of a fixed-point source position. That position starts at a programmable offset and advances by a programmable step for every output pixel.

Software first loads the coefficient bank through a write port, which is open only while an access-enable input is high. It then presents the line geometry on configuration inputs and latches it with a commit pulse. The latched geometry becomes active at the next line-start pulse. The block then takes exactly the configured number of source pixels from a valid/ready input stream into an internal line store. After that it emits exactly the configured number of resampled pixels on a valid/ready output stream. Downstream back-pressure pauses the output without losing the position.

Top module: `hscale_top`

## Requirements
- R1: Output pixel k is filtered at source position P = init + k*step, where step is an unsigned 16.16 value. The integer part P>>>16 selects the centre pixel and bits [15:11] of P select one of 32 phases.
- R2: Coefficient word 2p holds taps 0..3 of phase p and word 2p+1 holds taps 4..7, with tap t at bits [8(t mod 4)+7 : 8(t mod 4)] as a signed 8-bit value. Tap t multiplies source pixel (P>>>16) - 3 + t.
- R3: A tap index below 0 reads pixel 0, and a tap index at or above the input width reads the last pixel.
- R4: The sum of the eight products gets 32 added, is shifted right arithmetically by 6 and is clamped to 0..255.
- R5: A coefficient write has no effect unless the access-enable input is high in the same cycle.
- R6: coef_rdy_o is 0 after reset, is 0 in the cycle after any cycle with access enabled, and goes to 1 in the cycle after access-enable falls.
- R7: The configuration inputs are captured only on a commit pulse. The captured values take effect only at the next line start, and uncommitted changes have no effect.
- R8: After a line start, in_ready_o is high until exactly in-width pixels have been accepted. Exactly out-width pixels are then emitted, and neither stream moves afterwards until the next line start.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o and out_data_o hold, and no output pixel is lost or repeated.
- R10: After reset, out_valid_o, in_ready_o and coef_rdy_o are 0.
- R11: The initial position is a 20-bit two's-complement 16.16 value that is sign-extended, so 0xfc000 means -0.25 pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_access_i | input | 1 | Opens the coefficient bank for writing |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 6 | Coefficient word index (2*phase + half) |
| coef_data_i | input | 32 | Four signed 8-bit taps |
| coef_rdy_o | output | 1 | Coefficient loading complete |
| cfg_in_w_i | input | 7 | Source pixels per line (1..64) |
| cfg_out_w_i | input | 7 | Output pixels per line (1..64) |
| cfg_step_i | input | 32 | Source increment per output, 16.16 |
| cfg_init_i | input | 20 | Signed starting position, 16.16 |
| cfg_commit_i | input | 1 | Captures the configuration inputs |
| frame_start_i | input | 1 | Starts a line with the captured configuration |
| in_valid_i | input | 1 | Source pixel valid |
| in_data_i | input | 8 | Source pixel |
| in_ready_o | output | 1 | Line store accepts a pixel |
| out_valid_o | output | 1 | Output pixel valid |
| out_data_o | output | 8 | Output pixel |
| out_ready_i | input | 1 | Downstream accepts a pixel |

## Verification
A wrong position accumulator or phase slice shows up as wrong output values. With a linear-interpolation kernel, the first output that falls off a whole-pixel position already differs, so an upscale exposes the fault within two output pixels. A wrong edge clamp shows up only at the first or last few outputs of a line. The bench therefore uses short lines with negative starting offsets and positions past the right edge. Coefficient gating, configuration shadowing and stall handling are checked through the output values and counts of whole lines that follow the disturbing stimulus.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RUN  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hs_coef_bank.sv
module hs_coef_bank #(
  parameter int TAPS   = 8,
  parameter int PHASES = 32,
  parameter int COEF_W = 8,
  parameter int WORD_W = 32,
  localparam int TPW   = WORD_W / COEF_W,
  localparam int WPP   = TAPS / TPW,
  localparam int WORDS = PHASES * WPP,
  localparam int CA_W  = $clog2(WORDS),
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          access_i,
  input  logic                          we_i,
  input  logic [CA_W-1:0]               addr_i,
  input  logic [WORD_W-1:0]             data_i,
  input  logic [PH_W-1:0]               phase_i,
  output logic [TAPS-1:0][COEF_W-1:0]   taps_o,
  output logic                          rdy_o
);
  logic [WORD_W-1:0] mem_q [WORDS];
  logic              access_q;

  always_ff @(posedge clk_i) begin
    if (we_i && access_i) mem_q[addr_i] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      access_q <= 1'b0;
      rdy_o    <= 1'b0;
    end else begin
      access_q <= access_i;
      if (access_i)      rdy_o <= 1'b0;
      else if (access_q) rdy_o <= 1'b1;
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam int WSEL = t / TPW;
    localparam int BOFS = (t % TPW) * COEF_W;
    logic [CA_W-1:0] waddr;
    assign waddr     = CA_W'(phase_i) * CA_W'(WPP) + CA_W'(WSEL);
    assign taps_o[t] = mem_q[waddr][BOFS +: COEF_W];
  end

  assert_coef_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_i |=> (!$stable(phase_i) || $stable(taps_o)));
  assert_rdy_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_i |=> !rdy_o);
endmodule

// File: rtl/hs_line_buf.sv
module hs_line_buf #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 64,
  parameter int TAPS  = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [PIX_W-1:0]            wdata_i,
  input  logic [TAPS-1:0][AW-1:0]     raddr_i,
  output logic [TAPS-1:0][PIX_W-1:0]  rdata_o
);
  logic [PIX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_rd
    assign rdata_o[t] = mem_q[raddr_i[t]];
  end
endmodule

// File: rtl/hs_fir.sv
module hs_fir #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 8,
  parameter int SHIFT  = 6,
  localparam int PROD_W = COEF_W + PIX_W + 1,
  localparam int SUM_W  = PROD_W + $clog2(TAPS) + 1,
  localparam int PMAX   = (1 << PIX_W) - 1
) (
  input  logic [TAPS-1:0][PIX_W-1:0]  pix_i,
  input  logic [TAPS-1:0][COEF_W-1:0] coef_i,
  output logic [PIX_W-1:0]            pix_o
);
  logic signed [PROD_W-1:0] prod [TAPS];
  logic signed [SUM_W-1:0]  sum_s, biased, rnd;

  for (genvar t = 0; t < TAPS; t++) begin : g_mul
    assign prod[t] = $signed(coef_i[t]) * $signed({1'b0, pix_i[t]});
  end

  always_comb begin
    sum_s = '0;
    for (int t = 0; t < TAPS; t++) sum_s = sum_s + SUM_W'(prod[t]);
    biased = sum_s + $signed(SUM_W'(1 << (SHIFT - 1)));
    rnd    = biased >>> SHIFT;
    if (rnd < 0)                   pix_o = '0;
    else if (rnd > SUM_W'(PMAX))   pix_o = PIX_W'(PMAX);
    else                           pix_o = rnd[PIX_W-1:0];
  end
endmodule

// File: rtl/hscale_top.sv
module hscale_top import hs_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int MAX_W  = 64,
  parameter int TAPS   = 8,
  parameter int PHASES = 32,
  parameter int COEF_W = 8,
  parameter int WORD_W = 32,
  parameter int FRAC_W = 16,
  parameter int POS_W  = 32,
  parameter int INIT_W = 20,
  parameter int SHIFT  = 6,
  localparam int AW     = $clog2(MAX_W),
  localparam int WW     = $clog2(MAX_W + 1),
  localparam int PH_W   = $clog2(PHASES),
  localparam int WORDS  = PHASES * TAPS * COEF_W / WORD_W,
  localparam int CA_W   = $clog2(WORDS),
  localparam int CENTER = TAPS / 2 - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              coef_access_i,
  input  logic              coef_we_i,
  input  logic [CA_W-1:0]   coef_addr_i,
  input  logic [WORD_W-1:0] coef_data_i,
  output logic              coef_rdy_o,
  input  logic [WW-1:0]     cfg_in_w_i,
  input  logic [WW-1:0]     cfg_out_w_i,
  input  logic [POS_W-1:0]  cfg_step_i,
  input  logic [INIT_W-1:0] cfg_init_i,
  input  logic              cfg_commit_i,
  input  logic              frame_start_i,
  input  logic              in_valid_i,
  input  logic [PIX_W-1:0]  in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [PIX_W-1:0]  out_data_o,
  input  logic              out_ready_i
);
  hs_state_e state_q;
  logic [WW-1:0]     sh_in_w, sh_out_w, act_in_w, act_out_w;
  logic [POS_W-1:0]  sh_step, act_step;
  logic [INIT_W-1:0] sh_init, act_init;
  logic [WW-1:0]     wr_cnt_q, out_cnt_q;
  logic [POS_W-1:0]  acc_q;
  logic              fire, accept;

  logic signed [POS_W-1:0]   src_int, lim_s;
  logic signed [POS_W-1:0]   raw_idx [TAPS];
  logic [TAPS-1:0][AW-1:0]   rd_idx;
  logic [TAPS-1:0][PIX_W-1:0] taps_pix;
  logic [TAPS-1:0][COEF_W-1:0] taps_coef;
  logic [PH_W-1:0]           phase;
  logic [PIX_W-1:0]          filt_pix;

  assign in_ready_o = (state_q == ST_FILL);
  assign accept     = in_valid_i && in_ready_o;
  assign fire       = (state_q == ST_RUN) && (!out_valid_o || out_ready_i);
  assign phase      = acc_q[FRAC_W-1 -: PH_W];
  assign src_int    = $signed(acc_q) >>> FRAC_W;

  // source tap addresses, replicated at both line edges
  always_comb begin
    lim_s = POS_W'(act_in_w);
    for (int t = 0; t < TAPS; t++) begin
      raw_idx[t] = src_int + POS_W'(t) - POS_W'(CENTER);
      if (raw_idx[t] < 0)           rd_idx[t] = '0;
      else if (raw_idx[t] >= lim_s) rd_idx[t] = AW'(act_in_w - WW'(1));
      else                          rd_idx[t] = raw_idx[t][AW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_in_w  <= WW'(1);
      sh_out_w <= WW'(1);
      sh_step  <= POS_W'(1 << FRAC_W);
      sh_init  <= '0;
    end else if (cfg_commit_i) begin
      sh_in_w  <= cfg_in_w_i;
      sh_out_w <= cfg_out_w_i;
      sh_step  <= cfg_step_i;
      sh_init  <= cfg_init_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      act_in_w    <= WW'(1);
      act_out_w   <= WW'(1);
      act_step    <= POS_W'(1 << FRAC_W);
      act_init    <= '0;
      wr_cnt_q    <= '0;
      out_cnt_q   <= '0;
      acc_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      if (fire)             out_valid_o <= 1'b1;
      else if (out_ready_i) out_valid_o <= 1'b0;
      if (fire) out_data_o <= filt_pix;
      unique case (state_q)
        ST_IDLE: if (frame_start_i) begin
          act_in_w  <= sh_in_w;
          act_out_w <= sh_out_w;
          act_step  <= sh_step;
          act_init  <= sh_init;
          wr_cnt_q  <= '0;
          state_q   <= ST_FILL;
        end
        ST_FILL: if (accept) begin
          wr_cnt_q <= wr_cnt_q + WW'(1);
          if (wr_cnt_q == act_in_w - WW'(1)) begin
            acc_q     <= {{(POS_W-INIT_W){act_init[INIT_W-1]}}, act_init};
            out_cnt_q <= '0;
            state_q   <= ST_RUN;
          end
        end
        ST_RUN: if (fire) begin
          acc_q     <= acc_q + act_step;
          out_cnt_q <= out_cnt_q + WW'(1);
          if (out_cnt_q == act_out_w - WW'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  hs_line_buf #(.PIX_W(PIX_W), .DEPTH(MAX_W), .TAPS(TAPS)) u_line (
    .clk_i   (clk_i),
    .we_i    (accept),
    .waddr_i (wr_cnt_q[AW-1:0]),
    .wdata_i (in_data_i),
    .raddr_i (rd_idx),
    .rdata_o (taps_pix)
  );

  hs_coef_bank #(.TAPS(TAPS), .PHASES(PHASES), .COEF_W(COEF_W), .WORD_W(WORD_W)) u_coef (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .access_i (coef_access_i),
    .we_i     (coef_we_i),
    .addr_i   (coef_addr_i),
    .data_i   (coef_data_i),
    .phase_i  (phase),
    .taps_o   (taps_coef),
    .rdy_o    (coef_rdy_o)
  );

  hs_fir #(.PIX_W(PIX_W), .COEF_W(COEF_W), .TAPS(TAPS), .SHIFT(SHIFT)) u_fir (
    .pix_i  (taps_pix),
    .coef_i (taps_coef),
    .pix_o  (filt_pix)
  );

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  assert_accept_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (wr_cnt_q < act_in_w));
  assert_no_emit_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |=> !$rose(out_valid_o));
  for (genvar t = 0; t < TAPS; t++) begin : g_chk
    assert_tap_in_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_RUN) |-> (WW'(rd_idx[t]) < act_in_w));
  end
endmodule

// File: tb/hscale_top_tb_top.sv
module hscale_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        coef_access = 0, coef_we = 0;
  logic [5:0]  coef_addr = '0;
  logic [31:0] coef_data = '0;
  logic        coef_rdy;
  logic [6:0]  cfg_in_w = 7'd1, cfg_out_w = 7'd1;
  logic [31:0] cfg_step = 32'h10000;
  logic [19:0] cfg_init = '0;
  logic        cfg_commit = 0, frame_start = 0;
  logic        in_valid = 0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_ready = 0;
  logic [7:0]  out_data;

  hscale_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .coef_access_i(coef_access), .coef_we_i(coef_we), .coef_addr_i(coef_addr),
    .coef_data_i(coef_data), .coef_rdy_o(coef_rdy),
    .cfg_in_w_i(cfg_in_w), .cfg_out_w_i(cfg_out_w), .cfg_step_i(cfg_step),
    .cfg_init_i(cfg_init), .cfg_commit_i(cfg_commit), .frame_start_i(frame_start),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  int total = 0, bad = 0;
  int cf [32][8];
  int pix [64];
  int m_in_w, m_out_w, m_step, m_init;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_pix(int k);
    int pos, ip, ph, s, idx;
    pos = m_init + k * m_step;
    ip  = pos >>> 16;
    ph  = (pos >>> 11) & 31;
    s   = 0;
    for (int t = 0; t < 8; t++) begin
      idx = ip - 3 + t;
      if (idx < 0) idx = 0;
      if (idx > m_in_w - 1) idx = m_in_w - 1;
      s += cf[ph][t] * pix[idx];
    end
    s = (s + 32) >>> 6;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic write_word(int a, int d, bit acc);
    @(negedge clk);
    coef_access = acc; coef_we = 1; coef_addr = 6'(a); coef_data = 32'(d);
    @(negedge clk);
    coef_we = 0;
  endtask

  task automatic load_bank();
    @(negedge clk); coef_access = 1;
    @(negedge clk);
    chk(coef_rdy == 0, "R6 rdy low during access", int'(coef_rdy), 0);
    for (int p = 0; p < 32; p++)
      for (int h = 0; h < 2; h++)
        write_word(2 * p + h, {cf[p][4*h+3][7:0], cf[p][4*h+2][7:0],
                               cf[p][4*h+1][7:0], cf[p][4*h][7:0]}, 1);
    @(negedge clk); coef_access = 0;
    @(negedge clk); @(negedge clk);
    chk(coef_rdy == 1, "R6 rdy after access falls", int'(coef_rdy), 1);
  endtask

  task automatic commit(int iw, int ow, int st, int ini);
    @(negedge clk);
    cfg_in_w = 7'(iw); cfg_out_w = 7'(ow); cfg_step = 32'(st); cfg_init = 20'(ini);
    cfg_commit = 1;
    @(negedge clk); cfg_commit = 0;
    m_in_w = iw; m_out_w = ow; m_step = st; m_init = ini;
  endtask

  task automatic run_line(bit stall, string req);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    fork
      begin
        for (int i = 0; i < m_in_w; i++) begin
          @(negedge clk); in_valid = 1; in_data = 8'(pix[i]);
          #1;
          while (!in_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk); in_valid = 0;
      end
      begin
        int got = 0, cyc = 0;
        while (got < m_out_w) begin
          @(negedge clk);
          cyc++;
          out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
          #1;
          if (out_valid && out_ready) begin
            chk(int'(out_data) == ref_pix(got), req, int'(out_data), ref_pix(got));
            got++;
          end
        end
      end
    join
    @(negedge clk); out_ready = 1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R8 no extra output", int'(out_valid), 0);
    chk(in_ready == 0, "R8 no input after line", int'(in_ready), 0);
  endtask

  task automatic set_linear();
    for (int p = 0; p < 32; p++)
      for (int t = 0; t < 8; t++)
        cf[p][t] = (t == 3) ? 64 - 2 * p : (t == 4) ? 2 * p : 0;
  endtask

  task automatic set_ramp(int n);
    for (int i = 0; i < 64; i++) pix[i] = (i < n) ? (i * 29 + 7) % 256 : 0;
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R10 out_valid", int'(out_valid), 0);
    chk(in_ready == 0, "R10 in_ready", int'(in_ready), 0);
    chk(coef_rdy == 0, "R10 coef_rdy", int'(coef_rdy), 0);
  endtask

  task automatic t_identity();
    set_ramp(8);
    commit(8, 8, 32'h10000, 0);
    run_line(0, "R1 R2 identity");
  endtask

  task automatic t_upscale();
    set_ramp(8);
    commit(8, 16, (8 << 16) / 16, 0);
    run_line(0, "R1 R3 upscale x2 right edge");
  endtask

  task automatic t_downscale();
    set_ramp(16);
    commit(16, 6, (16 << 16) / 6, 0);
    run_line(0, "R1 downscale");
  endtask

  task automatic t_neg_init();
    set_ramp(10);
    commit(10, 12, (10 << 16) / 12, -16384);
    run_line(0, "R11 R3 negative start");
    commit(10, 10, 32'h10000, 32'h400);
    run_line(0, "R11 small positive start");
  endtask

  task automatic t_stall();
    set_ramp(12);
    commit(12, 20, (12 << 16) / 20, 0);
    run_line(1, "R9 stalled output");
  endtask

  task automatic t_locked();
    write_word(0, 32'h7f7f7f7f, 0);
    write_word(1, 32'h7f7f7f7f, 0);
    set_ramp(8);
    commit(8, 8, 32'h10000, 0);
    run_line(0, "R5 write without access ignored");
  endtask

  task automatic t_shadow();
    set_ramp(8);
    commit(8, 8, 32'h10000, 0);
    @(negedge clk);
    cfg_in_w = 7'd4; cfg_out_w = 7'd3; cfg_step = 32'h8000; cfg_init = 20'h00800;
    run_line(0, "R7 uncommitted cfg ignored");
  endtask

  task automatic t_clamp();
    for (int p = 0; p < 32; p++)
      for (int t = 0; t < 8; t++)
        cf[p][t] = (t == 3) ? 80 : (t == 2 || t == 4) ? -8 : 0;
    load_bank();
    for (int i = 0; i < 64; i++) pix[i] = 0;
    pix[3] = 255; pix[6] = 200; pix[7] = 200;
    commit(8, 8, 32'h10000, 0);
    run_line(0, "R4 round and clamp");
    chk(ref_pix(3) == 255, "R4 model high clamp", ref_pix(3), 255);
    chk(ref_pix(2) == 0, "R4 model low clamp", ref_pix(2), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    set_linear();
    load_bank();
    t_identity();
    t_upscale();
    t_downscale();
    t_neg_init();
    t_stall();
    t_locked();
    t_shadow();
    t_clamp();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule